// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one 32-bit timer channel that counts down. Software sets it up through a word-wide register port with four word registers: control, initial count, current count and status. A single-cycle reference tick input drives the count through a prescaler held in the control register. The channel can fire once or reload itself and run again.

When the count reaches zero, the channel sets a pending flag. The interrupt output is that flag gated by an interrupt-enable bit. Software clears the flag by writing a one to it.

The enable bit has a read-only active bit that mirrors it. A counter-reset bit reloads the count and reads back as zero. In a write that sets both counter reset and enable, counter reset wins.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the registers read as follows: control 0x00000005 (prescale 5, all other bits zero), initial count 0, current count 0, status 0. The interrupt output is low.
- R2: Register addresses are 0 for control, 1 for initial count, 2 for current count and 3 for status. In the control word, bit 30 is enable, bit 29 is interrupt enable, bit 27 is periodic mode, bit 26 is counter reset, bit 25 is the read-only active flag, and bits 7:0 are the prescale value. Every other control bit, and the counter-reset bit, always reads zero, and writes to them are dropped.
- R3: While enabled, the count decrements once every (prescale+1) ticks. After an enable, a counter reset or an initial-count write, the first decrement comes on the (prescale+1)-th tick. A cycle that writes control or initial count does no counting.
- R4: A control write with bit 26 set reloads the count from the initial-count register. If the same write also sets bit 30, the channel stays disabled.
- R5: A write to address 1 stores the value and loads it into the count in the same cycle.
- R6: Writes to address 2 are ignored. Reads at address 2 return the live count.
- R7: A decrement step taken while the count is 1 or 0 is an expiry, and it sets the pending flag. In periodic mode the count then takes the initial count and keeps running. In one-shot mode the count becomes 0 and enable and active both clear.
- R8: Setting enable sets active and starts counting. Clearing enable clears active and freezes the count. If the frozen count (after any counter reset in the same write) is 0, the expiry handling of R7 is applied.
- R9: Changing the prescale value leaves the current count unchanged.
- R10: The pending flag is bit 0 at address 3. Writing 1 to it clears the flag and writing 0 has no effect. When an expiry and a clear fall in the same cycle, the flag ends up set.
- R11: The interrupt output equals interrupt enable AND the pending flag at every cycle, and it follows a change in either one without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register at addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- active mirrors enable;
- the interrupt equals its gating term;
- an expiry leaves the pending flag set, and a one-shot expiry leaves the channel disabled;
- counter reset drops a simultaneous enable;
- an initial-count write lands in the count;
- the count register ignores writes while idle;
- unused control bits read zero.

Some behaviour appears only in the bench scenarios, which compare every register and the interrupt against a model after every cycle. These are the exact spacing of decrements for each prescale value, the count being kept across a prescale change, the expiry on disable at zero, and periodic reloading over many rounds.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BIT_EN      = 30;
  localparam int unsigned BIT_IE      = 29;
  localparam int unsigned BIT_PER     = 27;
  localparam int unsigned BIT_CRST    = 26;
  localparam int unsigned BIT_ACT     = 25;
  localparam int unsigned STAT_PEND   = 0;
  localparam logic [7:0]  PRE_RESET   = 8'd5;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl import tmr_pkg::*; #(
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oneshot_clr_i,
  output logic              en_o,
  output logic              act_o,
  output logic              ie_o,
  output logic              per_o,
  output logic              per_nxt_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic              crst_o,
  output logic              start_o,
  output logic              stop_o
);
  logic en_q, en_d, act_q, act_d, ie_q, ie_d, per_q, per_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic req_en;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[DATA_W-1], wdata_i[28], wdata_i[BIT_ACT:PRE_W]};
  assign req_en = wdata_i[BIT_EN] & ~wdata_i[BIT_CRST];

  always_comb begin
    en_d  = en_q;
    act_d = act_q;
    ie_d  = ie_q;
    per_d = per_q;
    pre_d = pre_q;
    if (wr_i) begin
      en_d  = req_en;
      act_d = req_en;
      ie_d  = wdata_i[BIT_IE];
      per_d = wdata_i[BIT_PER];
      pre_d = wdata_i[PRE_W-1:0];
    end else if (oneshot_clr_i) begin
      en_d  = 1'b0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
      ie_q  <= 1'b0;
      per_q <= 1'b0;
      pre_q <= PRE_W'(PRE_RESET);
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
      ie_q  <= ie_d;
      per_q <= per_d;
      pre_q <= pre_d;
    end
  end

  assign en_o      = en_q;
  assign act_o     = act_q;
  assign ie_o      = ie_q;
  assign per_o     = per_q;
  assign per_nxt_o = per_d;
  assign pre_o     = pre_q;
  assign crst_o    = wr_i & wdata_i[BIT_CRST];
  assign start_o   = wr_i & req_en & ~en_q;
  assign stop_o    = wr_i & ~req_en & en_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             step_o
);
  logic [PRE_W-1:0] sub_q, sub_d;
  logic at_end;

  assign at_end = (sub_q >= pre_i);
  assign step_o = run_i & at_end;

  always_comb begin
    sub_d = sub_q;
    if (restart_i)   sub_d = '0;
    else if (run_i)  sub_d = at_end ? '0 : sub_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             stop_i,
  input  logic             per_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic step_exp, stop_exp;

  assign base     = load_i ? load_val_i : cnt_q;
  assign step_exp = step_i & (cnt_q <= CNT_W'(1));
  assign stop_exp = stop_i & (base == '0);
  assign expire_o = step_exp | stop_exp;

  always_comb begin
    cnt_d = cnt_q;
    if (expire_o)     cnt_d = per_i ? reload_i : '0;
    else if (load_i)  cnt_d = load_val_i;
    else if (step_i)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_pending.sv
module tmr_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = ie_i & pend_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic wr_ctrl, wr_load, wr_stat, hold, run, restart, load;
  logic en, act, ie, per, per_nxt, crst, start, stop, step, expire, pend;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, load_val, reload_q, reload_d;
  logic [DATA_W-1:0] cnt_ext, load_ext, pre_ext, ctrl_rd;

  assign wr_ctrl = wr_en_i & (addr_i == REG_CTRL);
  assign wr_load = wr_en_i & (addr_i == REG_LOAD);
  assign wr_stat = wr_en_i & (addr_i == REG_STAT);
  assign hold    = wr_ctrl | wr_load;
  assign run     = en & tick_i & ~hold;
  assign load    = crst | wr_load;
  assign restart = load | start;
  assign load_val = wr_load ? wdata_i[CNT_W-1:0] : reload_q;

  always_comb begin
    reload_d = reload_q;
    if (wr_load) reload_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '0;
    else        reload_q <= reload_d;
  end

  tmr_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .wdata_i(wdata_i),
    .oneshot_clr_i(expire & ~per_nxt),
    .en_o(en), .act_o(act), .ie_o(ie), .per_o(per), .per_nxt_o(per_nxt),
    .pre_o(pre), .crst_o(crst), .start_o(start), .stop_o(stop)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
    .pre_i(pre), .step_o(step)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
    .step_i(step), .stop_i(stop), .per_i(per_nxt), .reload_i(reload_q),
    .cnt_o(cnt), .expire_o(expire)
  );

  tmr_pending u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(expire),
    .clr_i(wr_stat & wdata_i[STAT_PEND]), .ie_i(ie),
    .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    cnt_ext  = '0;
    load_ext = '0;
    pre_ext  = '0;
    cnt_ext[CNT_W-1:0]  = cnt;
    load_ext[CNT_W-1:0] = reload_q;
    pre_ext[PRE_W-1:0]  = pre;
    ctrl_rd = pre_ext;
    ctrl_rd[BIT_EN]  = en;
    ctrl_rd[BIT_IE]  = ie;
    ctrl_rd[BIT_PER] = per;
    ctrl_rd[BIT_ACT] = act;
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL:  rdata_o = ctrl_rd;
      REG_LOAD:  rdata_o = load_ext;
      REG_COUNT: rdata_o = cnt_ext;
      default:   rdata_o = {{(DATA_W-1){1'b0}}, pend};
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic             wd_en,
  input logic             wd_crst,
  input logic [CNT_W-1:0] wd_cnt,
  input logic [31:0]      rdata_o,
  input logic             irq_o,
  input logic             en,
  input logic             act,
  input logic             ie,
  input logic             per_nxt,
  input logic             pend,
  input logic             expire,
  input logic [CNT_W-1:0] cnt
);
  p_act_follows_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act == en);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ie && pend));

  p_oneshot_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_nxt) |=> !en);

  p_expire_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);

  p_crst_drops_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd0 && wd_en && wd_crst) |=> !en);

  p_load_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd1) |=> (cnt == $past(wd_cnt)));

  p_count_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd2 && !en) |=> $stable(cnt));

  p_ctrl_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd0) |-> (rdata_o[31] == 1'b0 && rdata_o[28] == 1'b0 &&
                          rdata_o[26] == 1'b0 && rdata_o[24:8] == '0));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wd_en(wdata_i[30]), .wd_crst(wdata_i[26]), .wd_cnt(wdata_i[CNT_W-1:0]),
  .rdata_o(rdata_o), .irq_o(irq_o), .en(en), .act(act), .ie(ie),
  .per_nxt(per_nxt), .pend(pend), .expire(expire), .cnt(cnt)
);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, tick_i, wr_en_i, irq_o;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  bit m_en, m_ie, m_per, m_pend;
  bit [7:0] m_pre, m_sub;
  bit [31:0] m_rl, m_cnt;
  bit n_en, n_ie, n_per, n_pend;
  bit [7:0] n_pre, n_sub;
  bit [31:0] n_rl, n_cnt;

  function automatic bit [31:0] exp_read(int k);
    bit [31:0] v;
    v = '0;
    case (k)
      0: begin v[7:0] = m_pre; v[30] = m_en; v[29] = m_ie; v[27] = m_per; v[25] = m_en; end
      1: v = m_rl;
      2: v = m_cnt;
      default: v[0] = m_pend;
    endcase
    return v;
  endfunction

  task automatic chk(string what, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("irq", {31'b0, irq_o}, {31'b0, m_ie & m_pend});
    for (int k = 0; k < 4; k++) begin
      addr_i = 2'(k);
      #1;
      chk($sformatf("reg%0d", k), rdata_o, exp_read(k));
    end
  endtask

  task automatic model_eval(bit we, bit [1:0] a, bit [31:0] d, bit tk);
    bit wc, wl, ws, hold, ne, start, stop, ld, stp, ex;
    bit [31:0] ldv, base;
    wc = we && a == 2'd0; wl = we && a == 2'd1; ws = we && a == 2'd3;
    n_en = m_en; n_ie = m_ie; n_per = m_per; n_pre = m_pre;
    n_rl = m_rl; n_cnt = m_cnt; n_sub = m_sub; n_pend = m_pend;
    start = 0; stop = 0; ld = 0; ldv = 0;
    if (wc) begin
      ne = d[30] && !d[26];
      start = ne && !m_en; stop = !ne && m_en;
      n_en = ne; n_ie = d[29]; n_per = d[27]; n_pre = d[7:0];
      if (d[26]) begin ld = 1; ldv = m_rl; end
    end
    if (wl) begin n_rl = d; ld = 1; ldv = d; end
    hold = wc || wl;
    stp  = m_en && tk && !hold && (m_sub >= m_pre);
    base = ld ? ldv : m_cnt;
    ex   = (stp && m_cnt <= 1) || (stop && base == 0);
    if (ex) begin
      n_cnt = n_per ? m_rl : 32'd0;
      if (!n_per) n_en = 0;
    end else if (ld) n_cnt = ldv;
    else if (stp) n_cnt = m_cnt - 1;
    if (ld || start) n_sub = 0;
    else if (m_en && tk && !hold) n_sub = stp ? 8'd0 : m_sub + 8'd1;
    if (ws && d[0]) n_pend = 0;
    if (ex) n_pend = 1;
  endtask

  task automatic cyc(bit we, bit [1:0] a, bit [31:0] d, bit tk);
    wr_en_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    model_eval(we, a, d, tk);
    @(posedge clk);
    #1;
    wr_en_i = 0; tick_i = 0;
    m_en = n_en; m_ie = n_ie; m_per = n_per; m_pre = n_pre;
    m_rl = n_rl; m_cnt = n_cnt; m_sub = n_sub; m_pend = n_pend;
    @(negedge clk);
    check_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd2, 32'd0, 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    rst_n = 0; tick_i = 0; wr_en_i = 0; addr_i = 0; wdata_i = 0;
    m_en = 0; m_ie = 0; m_per = 0; m_pend = 0; m_pre = 8'd5; m_sub = 0; m_rl = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1"; check_all();

    cur_req = "R2"; cyc(1, 2'd0, 32'hFFFF_FFFF, 1);
    cur_req = "R4"; cyc(1, 2'd0, 32'h0000_0000, 0);
    cur_req = "R5"; cyc(1, 2'd1, 32'd7, 0);
    cur_req = "R6"; cyc(1, 2'd2, 32'h1234, 1);
    cur_req = "R3"; cyc(1, 2'd0, 32'h6800_0001, 0); ticks(9);
    cur_req = "R9"; cyc(1, 2'd0, 32'h6800_0003, 0); ticks(8);
    cur_req = "R6"; cyc(1, 2'd2, 32'hFFFF, 1);
    cur_req = "R7"; ticks(30);
    cur_req = "R10"; cyc(1, 2'd3, 32'h0, 0); cyc(1, 2'd3, 32'h1, 0);
    cur_req = "R4"; cyc(1, 2'd0, 32'h6C00_0000, 0); ticks(2);
    cur_req = "R7"; cyc(1, 2'd1, 32'd2, 0); cyc(1, 2'd0, 32'h6000_0000, 0); ticks(5);
    cur_req = "R8"; cyc(1, 2'd1, 32'd5, 0); cyc(1, 2'd0, 32'h4000_0000, 0); ticks(2);
    cyc(1, 2'd0, 32'h0000_0000, 1); ticks(2);
    cyc(1, 2'd3, 32'h1, 0); cyc(1, 2'd1, 32'd0, 0);
    cyc(1, 2'd0, 32'h4000_0000, 0); cyc(1, 2'd0, 32'h2000_0000, 0);
    cur_req = "R11"; cyc(1, 2'd0, 32'h0000_0000, 0); cyc(1, 2'd0, 32'h2000_0000, 0);
    cur_req = "R10"; cyc(1, 2'd3, 32'h1, 0); cyc(1, 2'd1, 32'd1, 0);
    cyc(1, 2'd0, 32'h6000_0000, 0); cyc(1, 2'd3, 32'h1, 1);

    cur_req = "R3 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit [31:0] d;
      bit tk;
      r = int'($urandom % 100);
      d = $urandom;
      tk = ($urandom % 3) != 0;
      if (r < 6) begin
        d[7:0] = 8'($urandom % 4);
        d[26] = ($urandom % 8) == 0;
        d[30] = ($urandom % 4) != 0;
        cyc(1, 2'd0, d, tk);
      end else if (r < 10) cyc(1, 2'd1, $urandom % 12, tk);
      else if (r < 13)     cyc(1, 2'd3, d, tk);
      else if (r < 15)     cyc(1, 2'd2, d, tk);
      else                 cyc(0, 2'd0, 32'd0, tk);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule